// File: doc/BRIEF.md
# Card Data FIFO Byte Engine

This block sits between a processor bus and the byte-wide data lane of a storage card. It moves data through a 16-word FIFO of 32-bit entries and works in one direction at a time. In the card-to-FIFO direction it accepts bytes from the card with a valid/ready handshake and packs them into words, least significant byte first. In the FIFO-to-card direction it unpacks FIFO words into bytes in the same order and presents one byte per strobe cycle.

Software programs a transfer length in bytes and then writes a control byte that holds an enable bit and a direction bit. Setting the enable bit loads a byte countdown from the length and starts the engine. Software fills or drains the FIFO through a window of sixteen aliased word addresses. It can read the byte countdown, a rounded-up word countdown and a status word. The engine clears its own enable bit once the countdown is zero and the FIFO has drained.

Top module: `cdf_engine`

## Requirements
- R1: After reset, every register reads zero except STATUS, which reads 0x08 (FIFO-empty bit 3 set). card_rx_ready and card_tx_strobe are low.
- R2: A write to CTRL keeps only bits 7:0. Bit 0 is enable and bit 1 is direction (1 = card to FIFO, 0 = FIFO to card). A write with bit 0 set loads BYTECNT from LEN and clears STATUS bits 2:0.
- R3: card_rx_ready is high only while the engine is enabled in the card-to-FIFO direction, BYTECNT is non-zero, the FIFO is not full and no window write is in progress. Each byte accepted with valid and ready decrements BYTECNT by one.
- R4: Received bytes are packed least significant byte first. A word is pushed after its fourth byte, or after the final byte of the transfer. In that case the unused upper bytes are zero.
- R5: In the FIFO-to-card direction, each FIFO word is sent as bytes starting with bits 7:0, one byte in each cycle in which card_tx_strobe is high. Each byte decrements BYTECNT. Bytes left over in a word when BYTECNT reaches zero are discarded.
- R6: WORDCNT reads as (BYTECNT + 3) >> 2.
- R7: STATUS bit 0 is set when a transferred byte takes BYTECNT from one to zero.
- R8: CTRL bit 0 clears itself once BYTECNT is zero and the FIFO is empty. A start with LEN of zero therefore disables the engine without setting STATUS bit 0.
- R9: Every word address from 0x40 to 0x7C reaches the same FIFO. Reads return words in the order they were pushed.
- R10: A window read while the FIFO is empty returns zero and sets STATUS bit 1.
- R11: A window write while BYTECNT is zero is ignored. A window write while the FIFO is full is dropped and sets STATUS bit 2. STATUS bit 4 shows FIFO full.
- R12: Register offsets are LEN 0x00 (read/write), CTRL 0x04, BYTECNT 0x08, WORDCNT 0x0C and STATUS 0x10. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a window read pops the FIFO) |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd |
| card_rx_valid | input | 1 | The card offers a byte |
| card_rx_data | input | 8 | Byte from the card |
| card_rx_ready | output | 1 | The engine accepts the offered byte |
| card_tx_strobe | output | 1 | A byte to the card is presented this cycle |
| card_tx_data | output | 8 | Byte to the card |

## Verification
Three transfer shapes exercise the packing logic. A 10-byte receive ends on a partial word, and it shows whether the zero fill and the rounded word count are right. A 7-byte send splits its last word, and it shows whether the leftover bytes are discarded and the count stops at zero. A 68-byte receive fills the FIFO to the top. It shows the handshake stall, and it shows that a dropped write leaves the word order unchanged. The bench also tries a zero-length start, a wide control write, pops from an empty FIFO and a push after the count is exhausted. Together these separate the self-disable condition and the error flags from the normal data path.

// File: rtl/cdf_pkg.sv
package cdf_pkg;
    localparam int WORD_W    = 32;
    localparam int BYTE_W    = 8;
    localparam int LANES     = WORD_W / BYTE_W;
    localparam int LANE_W    = $clog2(LANES + 1);

    localparam int OFF_LEN   = 'h00;
    localparam int OFF_CTRL  = 'h04;
    localparam int OFF_BCNT  = 'h08;
    localparam int OFF_WCNT  = 'h0C;
    localparam int OFF_STAT  = 'h10;
    localparam int WIN_BASE  = 'h40;
    localparam int WIN_WORDS = 16;

    localparam int CTRL_EN   = 0;
    localparam int CTRL_DIR  = 1;

    localparam int ST_BLKEND = 0;
    localparam int ST_UNDER  = 1;
    localparam int ST_OVER   = 2;
    localparam int ST_EMPTY  = 3;
    localparam int ST_FULL   = 4;
endpackage

// File: rtl/cdf_word_fifo.sv
module cdf_word_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic          full,
    output logic [LW-1:0] level
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [LW-1:0]           lvl;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_pop, do_push;

    always_comb begin
        st_d    = st_q;
        do_pop  = pop && (st_q.lvl != '0);
        do_push = push && ((st_q.lvl != LW'(DEPTH)) || do_pop);
        if (do_push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.lvl = st_q.lvl + 1'b1;
            2'b01:   st_d.lvl = st_q.lvl - 1'b1;
            default: st_d.lvl = st_q.lvl;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.mem[st_q.rd];
    assign empty = (st_q.lvl == '0);
    assign full  = (st_q.lvl == LW'(DEPTH));
    assign level = st_q.lvl;
endmodule

// File: rtl/cdf_rx_pack.sv
module cdf_rx_pack
    import cdf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              take,
    input  logic              last,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              word_push,
    output logic [WORD_W-1:0] word
);
    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [1:0]        n;
    } pack_st_t;

    pack_st_t          st_d, st_q;
    logic [WORD_W-1:0] merged;

    always_comb begin
        merged    = st_q.acc | (WORD_W'(in_byte) << {st_q.n, 3'b000});
        word_push = take && ((st_q.n == 2'd3) || last);
        st_d      = st_q;
        if (clear) begin
            st_d = '0;
        end else if (take) begin
            if (word_push) begin
                st_d = '0;
            end else begin
                st_d.acc = merged;
                st_d.n   = st_q.n + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word = merged;
endmodule

// File: rtl/cdf_tx_unpack.sv
module cdf_tx_unpack
    import cdf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              step,
    output logic              have_byte,
    output logic [BYTE_W-1:0] out_byte
);
    typedef struct packed {
        logic [WORD_W-1:0] sh;
        logic [LANE_W-1:0] left;
    } unpack_st_t;

    unpack_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (load) begin
            st_d.sh   = load_word;
            st_d.left = LANE_W'(LANES);
        end else if (step) begin
            st_d.sh   = st_q.sh >> BYTE_W;
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign have_byte = (st_q.left != '0);
    assign out_byte  = st_q.sh[BYTE_W-1:0];
endmodule

// File: rtl/cdf_engine.sv
module cdf_engine
    import cdf_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 8,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              card_rx_valid,
    input  logic [7:0]        card_rx_data,
    output logic              card_rx_ready,
    output logic              card_tx_strobe,
    output logic [7:0]        card_tx_data
);
    typedef struct packed {
        logic [CNT_W-1:0] len;
        logic [7:0]       ctrl;
        logic [CNT_W-1:0] bcnt;
        logic             blk_end;
        logic             under;
        logic             over;
    } eng_st_t;

    eng_st_t st_d, st_q;

    logic              win_hit, ctrl_wr, ctrl_start;
    logic              eng_en, eng_dir_rd;
    logic [CNT_W-1:0]  bytecnt;
    logic              bus_push, push_ok, bus_pop, empty_pop;
    logic              rx_take, eng_load, tx_have, byte_done;
    logic              pk_push;
    logic [WORD_W-1:0] pk_word, fifo_head;
    logic              fifo_push, fifo_pop, fifo_empty, fifo_full;
    logic [LW-1:0]     fifo_level;
    logic [WORD_W-1:0] fifo_wdata;
    logic [CNT_W:0]    wsum;
    logic [31:0]       status;

    assign eng_en     = st_q.ctrl[CTRL_EN];
    assign eng_dir_rd = st_q.ctrl[CTRL_DIR];
    assign bytecnt    = st_q.bcnt;

    // ---- bus decode ----
    assign win_hit    = (int'(bus_addr) >= WIN_BASE) &&
                        (int'(bus_addr) <  WIN_BASE + 4 * WIN_WORDS);
    assign ctrl_wr    = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
    assign ctrl_start = ctrl_wr && bus_wdata[CTRL_EN];
    assign bus_push   = bus_wr && win_hit && (bytecnt != '0);
    assign push_ok    = bus_push && !fifo_full;
    assign bus_pop    = bus_rd && win_hit && !fifo_empty;
    assign empty_pop  = bus_rd && win_hit && fifo_empty;

    // ---- card side ----
    assign card_rx_ready  = eng_en && eng_dir_rd && (bytecnt != '0) &&
                            !fifo_full && !bus_push;
    assign rx_take        = card_rx_ready && card_rx_valid;
    assign card_tx_strobe = eng_en && !eng_dir_rd && (bytecnt != '0) && tx_have;
    assign eng_load       = eng_en && !eng_dir_rd && (bytecnt != '0) && !tx_have &&
                            !fifo_empty && !(bus_rd && win_hit);
    assign byte_done      = rx_take || card_tx_strobe;

    assign fifo_push  = push_ok || pk_push;
    assign fifo_wdata = push_ok ? bus_wdata : pk_word;
    assign fifo_pop   = bus_pop || eng_load;

    cdf_word_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fifo_push),
        .push_data (fifo_wdata),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .level     (fifo_level)
    );

    cdf_rx_pack u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (ctrl_start),
        .take      (rx_take),
        .last      (bytecnt == CNT_W'(1)),
        .in_byte   (card_rx_data),
        .word_push (pk_push),
        .word      (pk_word)
    );

    cdf_tx_unpack u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (ctrl_start || (card_tx_strobe && bytecnt == CNT_W'(1))),
        .load      (eng_load),
        .load_word (fifo_head),
        .step      (card_tx_strobe),
        .have_byte (tx_have),
        .out_byte  (card_tx_data)
    );

    // ---- next state ----
    always_comb begin
        st_d = st_q;
        if (bus_wr && bus_addr == ADDR_W'(OFF_LEN)) begin
            st_d.len = bus_wdata[CNT_W-1:0];
        end
        if (ctrl_wr) begin
            st_d.ctrl = bus_wdata[7:0];
        end else if (eng_en && bytecnt == '0 && fifo_empty) begin
            st_d.ctrl[CTRL_EN] = 1'b0;
        end
        if (ctrl_start) begin
            st_d.bcnt    = st_q.len;
            st_d.blk_end = 1'b0;
            st_d.under   = 1'b0;
            st_d.over    = 1'b0;
        end else begin
            if (byte_done) begin
                st_d.bcnt = bytecnt - 1'b1;
                if (bytecnt == CNT_W'(1)) st_d.blk_end = 1'b1;
            end
            if (empty_pop) st_d.under = 1'b1;
            if (bus_push && fifo_full) st_d.over = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // ---- read mux ----
    assign wsum = {1'b0, bytecnt} + (CNT_W + 1)'(3);

    always_comb begin
        status            = '0;
        status[ST_BLKEND] = st_q.blk_end;
        status[ST_UNDER]  = st_q.under;
        status[ST_OVER]   = st_q.over;
        status[ST_EMPTY]  = fifo_empty;
        status[ST_FULL]   = fifo_full;
        bus_rdata         = '0;
        if (win_hit) begin
            bus_rdata = fifo_empty ? '0 : fifo_head;
        end else begin
            case (int'(bus_addr))
                OFF_LEN:  bus_rdata = 32'(st_q.len);
                OFF_CTRL: bus_rdata = 32'(st_q.ctrl);
                OFF_BCNT: bus_rdata = 32'(bytecnt);
                OFF_WCNT: bus_rdata = 32'(wsum >> 2);
                OFF_STAT: bus_rdata = status;
                default:  bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/cdf_engine_chk.sv
module cdf_engine_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             eng_en,
    input logic             eng_dir_rd,
    input logic [CNT_W-1:0] bytecnt,
    input logic             ctrl_wr,
    input logic             ctrl_start,
    input logic             card_rx_ready,
    input logic             card_tx_strobe,
    input logic             rx_take,
    input logic             fifo_empty,
    input logic             fifo_full,
    input logic             bus_push,
    input logic             over_flag,
    input logic             blk_flag
);
    // R3
    rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_rx_ready |-> (eng_en && eng_dir_rd && bytecnt != '0 && !fifo_full));

    // R5
    tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        card_tx_strobe |-> (eng_en && !eng_dir_rd && bytecnt != '0 && !card_rx_ready));

    // R3
    cnt_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_start |=> (bytecnt <= $past(bytecnt)));

    // R7
    blk_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rx_take || card_tx_strobe) && bytecnt == CNT_W'(1) && !ctrl_start) |=> blk_flag);

    // R8
    self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_en && bytecnt == '0 && fifo_empty && !ctrl_wr) |=> !eng_en);

    // R11
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && bus_push && !ctrl_start) |=> over_flag);
endmodule

bind cdf_engine cdf_engine_chk #(.CNT_W(CNT_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .eng_en         (eng_en),
    .eng_dir_rd     (eng_dir_rd),
    .bytecnt        (bytecnt),
    .ctrl_wr        (ctrl_wr),
    .ctrl_start     (ctrl_start),
    .card_rx_ready  (card_rx_ready),
    .card_tx_strobe (card_tx_strobe),
    .rx_take        (rx_take),
    .fifo_empty     (fifo_empty),
    .fifo_full      (fifo_full),
    .bus_push       (bus_push),
    .over_flag      (st_q.over),
    .blk_flag       (st_q.blk_end)
);

// File: tb/cdf_engine_bench.sv
module cdf_engine_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        card_rx_valid = 1'b0;
    logic [7:0]  card_rx_data = '0;
    logic        card_rx_ready, card_tx_strobe;
    logic [7:0]  card_tx_data;

    int checks = 0;
    int errors = 0;
    int tx_seen = 0;
    logic [31:0] exp_words[$];
    logic [7:0]  exp_bytes[$];
    logic [31:0] acc_w = '0;
    int          acc_n = 0;
    logic [31:0] rd;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cdf_engine u_cdf_engine (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .card_rx_valid(card_rx_valid), .card_rx_data(card_rx_data),
        .card_rx_ready(card_rx_ready), .card_tx_strobe(card_tx_strobe),
        .card_tx_data(card_tx_data)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic read_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        bus_read(a, v);
        check(tag, v, exp);
    endtask

    task automatic pop_check(input string tag, input logic [7:0] a);
        logic [31:0] v;
        bus_read(a, v);
        if (exp_words.size() == 0) check(tag, v, 32'hxxxx_xxxx);
        else check(tag, v, exp_words.pop_front());
    endtask

    task automatic card_send(input logic [7:0] b);
        @(negedge clk);
        card_rx_valid = 1'b1; card_rx_data = b;
        #1;
        while (!card_rx_ready) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        card_rx_valid = 1'b0;
    endtask

    // scoreboard driver: record the expected packed words, then send the bytes
    task automatic feed(input int first, input int n, input int total, input logic [7:0] base);
        for (int i = first; i < first + n; i++) begin
            logic [7:0] b;
            b = base + 8'(i);
            acc_w = acc_w | (32'(b) << (8 * acc_n));
            acc_n++;
            if (acc_n == 4 || i == total - 1) begin
                exp_words.push_back(acc_w);
                acc_w = '0;
                acc_n = 0;
            end
            card_send(b);
        end
    endtask

    // scoreboard monitor for bytes going to the card (R5)
    always @(negedge clk) begin
        if (rst_n && card_tx_strobe) begin
            tx_seen++;
            if (exp_bytes.size() == 0) check("R5 unexpected byte", {24'h0, card_tx_data}, 32'hxxxx_xxxx);
            else check("R5 tx byte", {24'h0, card_tx_data}, {24'h0, exp_bytes.pop_front()});
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        read_check("R1 status", 8'h10, 32'h08);
        read_check("R1 ctrl", 8'h04, 32'h0);
        read_check("R1 bytecnt", 8'h08, 32'h0);
        #1 check("R1 rx_ready", {31'h0, card_rx_ready}, 32'h0);
        check("R1 tx_strobe", {31'h0, card_tx_strobe}, 32'h0);

        // R2 only low byte of control kept, no start without enable
        bus_write(8'h04, 32'h1234_56F0);
        read_check("R2 ctrl low byte", 8'h04, 32'hF0);
        read_check("R2 no load", 8'h08, 32'h0);
        bus_write(8'h04, 32'h0);
        read_check("R12 unmapped", 8'h20, 32'h0);

        // receive 10 bytes: partial final word
        bus_write(8'h00, 32'd10);
        read_check("R12 len readback", 8'h00, 32'd10);
        bus_write(8'h04, 32'h3);
        read_check("R2 bytecnt loaded", 8'h08, 32'd10);
        read_check("R6 wordcnt 10", 8'h0C, 32'd3);
        feed(0, 5, 10, 8'hA0);
        read_check("R3 bytecnt after 5", 8'h08, 32'd5);
        read_check("R6 wordcnt 5", 8'h0C, 32'd2);
        feed(5, 5, 10, 8'hA0);
        read_check("R7 status blk end", 8'h10, 32'h01);
        read_check("R6 wordcnt 0", 8'h0C, 32'd0);
        pop_check("R4 word0 via 0x40", 8'h40);
        pop_check("R9 word1 via 0x5C", 8'h5C);
        pop_check("R4 partial word via 0x7C", 8'h7C);
        repeat (3) @(negedge clk);
        read_check("R8 enable cleared", 8'h04, 32'h02);
        read_check("R10 empty pop zero", 8'h44, 32'h0);
        read_check("R10 underrun flag", 8'h10, 32'h0B);

        // send 7 bytes from two words
        bus_write(8'h00, 32'd7);
        bus_write(8'h04, 32'h1);
        read_check("R2 flags cleared", 8'h10, 32'h08);
        exp_bytes.push_back(8'h44); exp_bytes.push_back(8'h33);
        exp_bytes.push_back(8'h22); exp_bytes.push_back(8'h11);
        exp_bytes.push_back(8'h88); exp_bytes.push_back(8'h77);
        exp_bytes.push_back(8'h66);
        tx_seen = 0;
        bus_write(8'h40, 32'h1122_3344);
        bus_write(8'h7C, 32'h5566_7788);
        repeat (20) @(negedge clk);
        check("R5 byte count", 32'(tx_seen), 32'd7);
        read_check("R5 bytecnt zero", 8'h08, 32'h0);
        read_check("R7 status after send", 8'h10, 32'h09);
        read_check("R8 enable cleared tx", 8'h04, 32'h00);
        bus_write(8'h40, 32'hDEAD_BEEF);
        repeat (4) @(negedge clk);
        read_check("R11 push ignored", 8'h10, 32'h09);
        check("R11 no strobe", 32'(tx_seen), 32'd7);

        // receive 68 bytes: FIFO fills, stall and drop
        bus_write(8'h00, 32'd68);
        bus_write(8'h04, 32'h3);
        feed(0, 64, 68, 8'h00);
        @(negedge clk);
        card_rx_valid = 1'b1;
        #1 check("R3 ready low when full", {31'h0, card_rx_ready}, 32'h0);
        card_rx_valid = 1'b0;
        read_check("R11 full flag", 8'h10, 32'h10);
        bus_write(8'h60, 32'hBAD0_BAD0);
        read_check("R11 overrun flag", 8'h10, 32'h14);
        pop_check("R9 first after drop", 8'h48);
        feed(64, 4, 68, 8'h00);
        for (int k = 0; k < 16; k++) pop_check("R9 drain", 8'(8'h40 + 4 * k));
        repeat (3) @(negedge clk);
        read_check("R7 final status", 8'h10, 32'h0D);
        read_check("R8 enable cleared rx", 8'h04, 32'h02);

        // zero length start
        bus_write(8'h00, 32'd0);
        bus_write(8'h04, 32'h3);
        repeat (3) @(negedge clk);
        read_check("R8 zero length", 8'h04, 32'h02);
        read_check("R8 no blk end", 8'h10, 32'h08);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule